// File: doc/BRIEF.md
# I2C Bit-Level Master Engine

This block drives the two wires of an I2C bus as a master, one bus phase at a time. A controller hands it a single command (generate a start condition, generate a stop condition, shift out a byte, shift in a byte, or free a stuck bus). The engine turns that command into SCL and SDA transitions placed on a grid of quarter SCL periods. When it finishes, it raises a one-cycle done pulse. With that pulse it reports the acknowledge level it sampled after an outgoing byte, or the byte it shifted in.

SCL is driven push-pull by the engine. SDA is open-drain: the engine only ever pulls it low through an output enable, and an external pull-up supplies the high level. The length of one quarter period is a parameter counted in system clocks. Clock stretching, arbitration, slave operation and the sequencing of whole transfers are left to the controller.

Top module: `i2cb_engine`

## Requirements
- R1: While reset is low and right after it, scl_o is 1, sda_oe is 0, cmd_ready is 1 and done is 0.
- R2: A command is taken on a clock edge where cmd_valid and cmd_ready are both 1. The opcode encoding is 0 start, 1 stop, 2 byte write, 3 byte read, 4 bus recovery. cmd_ready stays 0 until the command ends. done is then 1 for exactly one cycle, and cmd_ready is 1 in that cycle.
- R3: One quarter lasts QUARTER_CYC clocks. Start and stop take 4 quarters, a write 37, a read 29 and a recovery 41. Line changes for quarter k take effect on the edge 1+k*QUARTER_CYC clocks after the accepting edge. done is 1 in the cycle after edge N*QUARTER_CYC, where N is the command's quarter count. Once SCL rises it stays high for at least one more clock.
- R4: Start: quarter 0 leaves both lines unchanged, quarter 1 releases SDA, quarter 2 raises SCL, and quarter 3 pulls SDA low.
- R5: Stop: quarter 0 lowers SCL, quarter 1 pulls SDA low, quarter 2 raises SCL, and quarter 3 releases SDA.
- R6: Write sends cmd_wdata MSB first, four quarters per bit. SCL goes low in the first quarter, SDA is set to the bit in the second (pulled low for 0, released for 1), SCL rises in the third, and the fourth quarter leaves the lines unchanged.
- R7: After the 8 data bits, a write spends 5 quarters on the acknowledge slot: SCL low, SDA released, SCL high, a hold quarter, then SCL low. sda_i sampled at the end of the hold quarter is reported on ack_n with done (0 = acknowledged).
- R8: Read spends 3 quarters per bit. The first quarter lowers SCL and releases SDA, the second raises SCL, and sda_i is sampled at the end of the second. Bits enter MSB first, and the full byte is on rx_byte with done. ack_n is 0 with done after a read.
- R9: After the 8 read bits the engine spends 5 quarters on the acknowledge slot: SCL low; SDA pulled low if cmd_ack_n is 0, released if it is 1; SCL high; a hold quarter; SCL low.
- R10: Recovery: quarter 0 sets SCL high and releases SDA. Then come 9 SCL pulses of 4 quarters each (low in the first two, high in the last two) with SDA left released. A full stop sequence (R5) ends it.
- R11: sda_o is always 0. While the engine is idle, scl_o and sda_oe do not change.
- R12: Opcodes 5, 6 and 7 are consumed without effect: no done pulse, no line change, and cmd_ready stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle and able to take a command |
| cmd_op | input | 3 | Command opcode (R2) |
| cmd_wdata | input | BYTE_W | Byte to send for a write |
| cmd_ack_n | input | 1 | Acknowledge level to send after a read (0 = ACK) |
| scl_o | output | 1 | SCL level |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_o | output | 1 | SDA output data, constant 0 |
| sda_i | input | 1 | Sensed SDA level |
| done | output | 1 | One-cycle end-of-command pulse |
| ack_n | output | 1 | Sampled acknowledge from a write |
| rx_byte | output | BYTE_W | Byte received by the last read |

## Verification
A wrong unit or sub-step count in this engine shows up as a wrong SCL or SDA level at the midpoint of the very next quarter. The lines are compared against an independently computed quarter-by-quarter model on every quarter of every command, so such a fault is seen within one quarter. Faults in the shift registers show up as a misplaced SDA bit during a write slot, or a wrong rx_byte at the done pulse. Sweeping all 256 byte values in both directions exposes any bit-position or ordering error. A miscounted command length moves the done pulse off its computed cycle.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

   typedef enum logic [2:0] {
      OP_START   = 3'd0,
      OP_STOP    = 3'd1,
      OP_WRITE   = 3'd2,
      OP_READ    = 3'd3,
      OP_RECOVER = 3'd4
   } i2cb_op_e;

   // requested change of one bus line at the start of a quarter
   typedef enum logic [1:0] {
      LN_KEEP = 2'd0,
      LN_LOW  = 2'd1,
      LN_HIGH = 2'd2
   } i2cb_ln_e;

   typedef struct packed {
      i2cb_ln_e scl;
      i2cb_ln_e sda;     // LN_LOW = pull down, LN_HIGH = release
      logic     sample;  // capture sda_i at end of quarter
      logic     last_q;  // final quarter of the command
   } i2cb_act_t;

   function automatic logic op_known(input logic [2:0] op);
      return op <= 3'd4;
   endfunction

   // four-quarter stop pattern, shared by stop and recovery
   function automatic i2cb_act_t stop_step(input logic [2:0] sub);
      i2cb_act_t a;
      a = '{scl: LN_KEEP, sda: LN_KEEP, sample: 1'b0, last_q: 1'b0};
      case (sub)
         3'd0: a.scl = LN_LOW;
         3'd1: a.sda = LN_LOW;
         3'd2: a.scl = LN_HIGH;
         3'd3: begin a.sda = LN_HIGH; a.last_q = 1'b1; end
         default: ;
      endcase
      return a;
   endfunction

endpackage

// File: rtl/i2cb_qtick.sv
module i2cb_qtick #(
   parameter int QUARTER_CYC = 125
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic q_first,
   output logic q_last
);

   if (QUARTER_CYC < 1) begin : g_bad_len
      $error("i2cb_qtick: QUARTER_CYC must be at least 1");
   end

   if (QUARTER_CYC == 1) begin : g_single
      assign q_first = run;
      assign q_last  = run;
   end else begin : g_count
      localparam int CW = $clog2(QUARTER_CYC);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         cnt <= '0;
         else if (!run)                      cnt <= '0;
         else if (cnt == CW'(QUARTER_CYC-1)) cnt <= '0;
         else                                cnt <= cnt + CW'(1);
      end

      assign q_first = run && (cnt == '0);
      assign q_last  = run && (cnt == CW'(QUARTER_CYC-1));
   end

endmodule

// File: rtl/i2cb_step_dec.sv
module i2cb_step_dec
   import i2cb_pkg::*;
#(
   parameter int BYTE_W         = 8,
   parameter int RECOVER_PULSES = 9,
   parameter int UW             = 4
) (
   input  i2cb_op_e   op,
   input  logic [UW-1:0] unit,
   input  logic [2:0] sub,
   input  logic       tx_bit,
   input  logic       ack_drv,
   output i2cb_act_t  act,
   output logic       unit_end
);

   localparam logic [UW-1:0] DATA_UNITS = UW'(BYTE_W);
   localparam logic [UW-1:0] LAST_PULSE = UW'(RECOVER_PULSES);

   always_comb begin
      act      = '{scl: LN_KEEP, sda: LN_KEEP, sample: 1'b0, last_q: 1'b0};
      unit_end = 1'b0;
      case (op)
         OP_START: begin
            case (sub)
               3'd1: act.sda = LN_HIGH;
               3'd2: act.scl = LN_HIGH;
               3'd3: begin act.sda = LN_LOW; act.last_q = 1'b1; end
               default: ;
            endcase
         end
         OP_STOP: act = stop_step(sub);
         OP_WRITE: begin
            if (unit < DATA_UNITS) begin
               case (sub)
                  3'd0: act.scl = LN_LOW;
                  3'd1: act.sda = tx_bit ? LN_HIGH : LN_LOW;
                  3'd2: act.scl = LN_HIGH;
                  3'd3: unit_end = 1'b1;
                  default: ;
               endcase
            end else begin
               case (sub)
                  3'd0: act.scl = LN_LOW;
                  3'd1: act.sda = LN_HIGH;
                  3'd2: act.scl = LN_HIGH;
                  3'd3: act.sample = 1'b1;
                  3'd4: begin act.scl = LN_LOW; act.last_q = 1'b1; end
                  default: ;
               endcase
            end
         end
         OP_READ: begin
            if (unit < DATA_UNITS) begin
               case (sub)
                  3'd0: begin act.scl = LN_LOW; act.sda = LN_HIGH; end
                  3'd1: begin act.scl = LN_HIGH; act.sample = 1'b1; end
                  3'd2: unit_end = 1'b1;
                  default: ;
               endcase
            end else begin
               case (sub)
                  3'd0: act.scl = LN_LOW;
                  3'd1: act.sda = ack_drv ? LN_HIGH : LN_LOW;
                  3'd2: act.scl = LN_HIGH;
                  3'd4: begin act.scl = LN_LOW; act.last_q = 1'b1; end
                  default: ;
               endcase
            end
         end
         OP_RECOVER: begin
            if (unit == '0) begin
               act.scl  = LN_HIGH;
               act.sda  = LN_HIGH;
               unit_end = 1'b1;
            end else if (unit <= LAST_PULSE) begin
               case (sub)
                  3'd0: act.scl = LN_LOW;
                  3'd2: act.scl = LN_HIGH;
                  3'd3: unit_end = 1'b1;
                  default: ;
               endcase
            end else begin
               act = stop_step(sub);
            end
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/i2cb_engine.sv
module i2cb_engine
   import i2cb_pkg::*;
#(
   parameter int QUARTER_CYC    = 125,
   parameter int BYTE_W         = 8,
   parameter int RECOVER_PULSES = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [2:0]        cmd_op,
   input  logic [BYTE_W-1:0] cmd_wdata,
   input  logic              cmd_ack_n,
   output logic              scl_o,
   output logic              sda_oe,
   output logic              sda_o,
   input  logic              sda_i,
   output logic              done,
   output logic              ack_n,
   output logic [BYTE_W-1:0] rx_byte
);

   localparam int UNIT_MAX = ((BYTE_W > RECOVER_PULSES) ? BYTE_W : RECOVER_PULSES) + 1;
   localparam int UW       = $clog2(UNIT_MAX + 1);

   if (BYTE_W < 2) begin : g_bad_width
      $error("i2cb_engine: BYTE_W must be at least 2");
   end
   if (RECOVER_PULSES < 1) begin : g_bad_pulses
      $error("i2cb_engine: RECOVER_PULSES must be at least 1");
   end

   logic              busy;
   i2cb_op_e          op_q;
   logic [UW-1:0]     unit;
   logic [2:0]        sub;
   logic [BYTE_W-1:0] tx_sh;
   logic [BYTE_W-1:0] rx_sh;
   logic              ack_drv_q;
   logic              ack_n_q;
   logic              done_q;
   logic              scl_q;
   logic              oe_q;
   logic              q_first;
   logic              q_last;
   logic              unit_end;
   logic              accept;
   i2cb_act_t         act;

   assign cmd_ready = !busy;
   assign accept    = cmd_valid && !busy && op_known(cmd_op);

   i2cb_qtick #(.QUARTER_CYC(QUARTER_CYC)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (busy),
      .q_first (q_first),
      .q_last  (q_last)
   );

   i2cb_step_dec #(
      .BYTE_W         (BYTE_W),
      .RECOVER_PULSES (RECOVER_PULSES),
      .UW             (UW)
   ) u_dec (
      .op       (op_q),
      .unit     (unit),
      .sub      (sub),
      .tx_bit   (tx_sh[BYTE_W-1]),
      .ack_drv  (ack_drv_q),
      .act      (act),
      .unit_end (unit_end)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         op_q      <= OP_START;
         unit      <= '0;
         sub       <= '0;
         tx_sh     <= '0;
         rx_sh     <= '0;
         ack_drv_q <= 1'b1;
         ack_n_q   <= 1'b0;
         done_q    <= 1'b0;
         scl_q     <= 1'b1;
         oe_q      <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            busy      <= 1'b1;
            op_q      <= i2cb_op_e'(cmd_op);
            unit      <= '0;
            sub       <= '0;
            tx_sh     <= cmd_wdata;
            ack_drv_q <= cmd_ack_n;
            ack_n_q   <= 1'b0;
         end
         if (busy && q_first) begin
            case (act.scl)
               LN_LOW:  scl_q <= 1'b0;
               LN_HIGH: scl_q <= 1'b1;
               default: ;
            endcase
            case (act.sda)
               LN_LOW:  oe_q <= 1'b1;
               LN_HIGH: oe_q <= 1'b0;
               default: ;
            endcase
         end
         if (busy && q_last) begin
            if (act.sample) begin
               if (op_q == OP_READ) rx_sh   <= {rx_sh[BYTE_W-2:0], sda_i};
               else                 ack_n_q <= sda_i;
            end
            if (act.last_q) begin
               busy   <= 1'b0;
               done_q <= 1'b1;
            end else if (unit_end) begin
               unit <= unit + UW'(1);
               sub  <= '0;
               if (op_q == OP_WRITE) tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
            end else begin
               sub <= sub + 3'd1;
            end
         end
      end
   end

   assign scl_o   = scl_q;
   assign sda_oe  = oe_q;
   assign sda_o   = 1'b0;
   assign done    = done_q;
   assign ack_n   = ack_n_q;
   assign rx_byte = rx_sh;

endmodule

// File: rtl/i2cb_engine_chk.sv
module i2cb_engine_chk (
   input logic clk,
   input logic rst_n,
   input logic cmd_ready,
   input logic done,
   input logic scl_o,
   input logic sda_oe
);

   // R2: completion pulse lasts a single cycle
   assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R2: completion follows a cycle in which the engine was busy
   assert_done_after_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !$past(cmd_ready));

   // R2: engine is ready again in the completion cycle
   assert_ready_at_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> cmd_ready);

   // R11: bus lines stay put while idle
   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_ready && $past(cmd_ready)) |-> ($stable(scl_o) && $stable(sda_oe)));

   // R3: SCL high phase is never a single-clock glitch
   assert_scl_high_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_o) |=> scl_o);

endmodule

bind i2cb_engine i2cb_engine_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_ready (cmd_ready),
   .done      (done),
   .scl_o     (scl_o),
   .sda_oe    (sda_oe)
);

// File: tb/sim_i2cb_engine.sv
module sim_i2cb_engine;

   localparam int QC = 3;
   localparam int BW = 8;
   localparam int RP = 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic          cmd_ready;
   logic [2:0]    cmd_op = 3'd0;
   logic [BW-1:0] cmd_wdata = '0;
   logic          cmd_ack_n = 1'b1;
   logic          scl_o, sda_oe, sda_o;
   logic          sda_i = 1'b1;
   logic          done, ack_n;
   logic [BW-1:0] rx_byte;

   int n_vec = 0;
   int n_bad = 0;
   logic m_scl = 1'b1;
   logic m_oe  = 1'b0;

   always #2 clk = ~clk;

   i2cb_engine #(.QUARTER_CYC(QC), .BYTE_W(BW), .RECOVER_PULSES(RP)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .cmd_wdata(cmd_wdata), .cmd_ack_n(cmd_ack_n),
      .scl_o(scl_o), .sda_oe(sda_oe), .sda_o(sda_o), .sda_i(sda_i),
      .done(done), .ack_n(ack_n), .rx_byte(rx_byte)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int quarters(input int op);
      case (op)
         2: return 37;
         3: return 29;
         4: return 41;
         default: return 4;
      endcase
   endfunction

   function automatic logic [3:0] stop_pat(input int s);
      case (s)
         0: return 4'b1000;
         1: return 4'b0011;
         2: return 4'b1100;
         3: return 4'b0010;
         default: return 4'b0000;
      endcase
   endfunction

   // {change scl, new scl, change oe, new oe} for quarter k
   function automatic logic [3:0] exp_act(input int op, input int k,
                                          input logic [7:0] wd, input logic ackn);
      int s;
      case (op)
         0: begin // R4
            case (k)
               1: return 4'b0010;
               2: return 4'b1100;
               3: return 4'b0011;
               default: return 4'b0000;
            endcase
         end
         1: return stop_pat(k); // R5
         2: begin
            if (k < 32) begin // R6
               s = k % 4;
               case (s)
                  0: return 4'b1000;
                  1: return {2'b00, 1'b1, ~wd[7 - k/4]};
                  2: return 4'b1100;
                  default: return 4'b0000;
               endcase
            end
            s = k - 32; // R7
            case (s)
               0: return 4'b1000;
               1: return 4'b0010;
               2: return 4'b1100;
               4: return 4'b1000;
               default: return 4'b0000;
            endcase
         end
         3: begin
            if (k < 24) begin // R8
               s = k % 3;
               case (s)
                  0: return 4'b1010;
                  1: return 4'b1100;
                  default: return 4'b0000;
               endcase
            end
            s = k - 24; // R9
            case (s)
               0: return 4'b1000;
               1: return {2'b00, 1'b1, ~ackn};
               2: return 4'b1100;
               4: return 4'b1000;
               default: return 4'b0000;
            endcase
         end
         default: begin // R10
            if (k == 0) return 4'b1110;
            if (k <= 36) begin
               s = (k - 1) % 4;
               if (s == 0) return 4'b1000;
               if (s == 2) return 4'b1100;
               return 4'b0000;
            end
            return stop_pat(k - 37);
         end
      endcase
   endfunction

   task automatic run_cmd(input int op, input logic [7:0] wd, input logic ackn,
                          input logic ack_in, input logic [7:0] sbyte);
      logic [3:0] e;
      int n;
      n = quarters(op);
      @(negedge clk);
      cmd_op    = 3'(op);
      cmd_wdata = wd;
      cmd_ack_n = ackn;
      cmd_valid = 1'b1;
      sda_i     = (op == 2) ? ack_in : 1'b1;
      chk("R2", "ready before accept", int'(cmd_ready), 1);
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      for (int k = 0; k < n; k++) begin
         repeat ((k == 0) ? 1 : QC) @(posedge clk);
         @(negedge clk);
         e = exp_act(op, k, wd, ackn);
         if (e[3]) m_scl = e[2];
         if (e[1]) m_oe  = e[0];
         chk("R3", $sformatf("op%0d q%0d scl", op, k), int'(scl_o), int'(m_scl));
         chk("R3", $sformatf("op%0d q%0d sda_oe", op, k), int'(sda_oe), int'(m_oe));
         chk("R11", "sda_o low", int'(sda_o), 0);
         chk("R2", "busy ready low / no early done", int'({cmd_ready, done}), 0);
         if (op == 3 && k < 24 && (k % 3) == 0) sda_i = sbyte[7 - k/3];
      end
      repeat (QC - 1) @(posedge clk);
      @(negedge clk);
      chk("R2", $sformatf("op%0d done pulse", op), int'(done), 1);
      chk("R2", "ready at done", int'(cmd_ready), 1);
      if (op == 2) chk("R7", $sformatf("ack_n wd=%0h", wd), int'(ack_n), int'(ack_in));
      if (op == 3) begin
         chk("R8", "rx_byte", int'(rx_byte), int'(sbyte));
         chk("R8", "ack_n after read", int'(ack_n), 0);
      end
      @(negedge clk);
      chk("R2", "done single cycle", int'(done), 0);
      sda_i = 1'b1;
   endtask

   task automatic bad_op(input int op);
      @(negedge clk);
      cmd_op    = 3'(op);
      cmd_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      for (int c = 0; c < 20; c++) begin
         chk("R12", $sformatf("op%0d ready/done", op), int'({cmd_ready, done}), 2);
         chk("R12", $sformatf("op%0d lines", op), int'({scl_o, sda_oe}), int'({m_scl, m_oe}));
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL R3 watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "reset scl", int'(scl_o), 1);
      chk("R1", "reset oe", int'(sda_oe), 0);
      chk("R1", "reset ready/done", int'({cmd_ready, done}), 2);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1", "idle lines", int'({scl_o, sda_oe, sda_o}), 4);
      chk("R1", "idle ready/done", int'({cmd_ready, done}), 2);

      run_cmd(4, 8'h00, 1'b1, 1'b1, 8'h00);   // R10 recovery
      bad_op(5);                              // R12
      run_cmd(0, 8'h00, 1'b1, 1'b1, 8'h00);   // R4 start
      for (int v = 0; v < 256; v++)
         run_cmd(2, 8'(v), 1'b1, ^(8'(v)), 8'h00);          // R6 R7
      bad_op(6);
      for (int v = 0; v < 256; v++)
         run_cmd(3, 8'h00, v[0], 1'b1, 8'(v ^ 8'h5A));      // R8 R9
      run_cmd(1, 8'h00, 1'b1, 1'b1, 8'h00);   // R5 stop
      bad_op(7);
      repeat (4) @(negedge clk);
      chk("R11", "idle after stop", int'({scl_o, sda_oe}), 2);

      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule